// File: doc/BRIEF.md
# SMT Resource Balancing Throttle

This block sits beside the dispatch stage of a two-thread simultaneous-multithreading core. It tracks how much of the shared machine each thread is using. When one thread starts to crowd out the other, it throttles that thread only. Each congestion cause has its own remedy:

- Excess completion-table occupancy leads to a priority-reduction request.
- A build-up of outstanding L2 load misses leads to a decode inhibit.
- A pending long-running synchronizing instruction leads to a one-cycle flush of the thread's undispatched instructions, followed by a decode hold.

Thresholds and release margins come in as programmable values. A threshold of zero switches its check off. Occupancy and miss throttles release with hysteresis, so a count that hovers at the limit does not toggle the throttle.

Each cause runs its own state machine, and all outputs decode from state registers.

The occupancy arbiter keeps one machine per thread with states `OC_NORMAL` and `OC_REDUCED`:
- Transition *reduce*: `OC_NORMAL` to `OC_REDUCED`.
- Transition *restore*: `OC_REDUCED` to `OC_NORMAL`.

The miss gate has states `MS_CLEAR` and `MS_INHIBIT`:
- Transition *choke*: `MS_CLEAR` to `MS_INHIBIT`.
- Transition *drain*: `MS_INHIBIT` to `MS_CLEAR`.

The sync controller has states `SY_IDLE`, `SY_FLUSH` and `SY_HOLD`:
- Transition *catch*: `SY_IDLE` to `SY_FLUSH`.
- Transition *settle*: `SY_FLUSH` to `SY_HOLD`, taken while the pending flag stays high.
- Transition *abort*: `SY_FLUSH` to `SY_IDLE`, taken when the flag has already dropped.
- Transition *resume*: `SY_HOLD` to `SY_IDLE`.

Every output changes in the cycle after the clock edge that samples the causing input.

Top module: `rbt_throttle`

## Requirements
- R1: While `occ_limit` is nonzero, a thread whose occupancy count is strictly greater than `occ_limit` enters the reduced-priority state. Its bit of `prio_down` (bit 0 = thread 0, bit 1 = thread 1) rises one cycle later, provided the other thread is not reduced and does not win the tie rule of R3. A count equal to the limit does not trigger it.
- R2: A reduced thread returns to normal priority when its count plus `occ_margin` is strictly less than `occ_limit`, or when its count is zero. Otherwise it stays reduced.
- R3: At most one bit of `prio_down` is set at any time. When both threads are over the limit while neither is reduced, only the thread with the higher count is reduced, and thread 0 wins on equal counts. A thread cannot enter the reduced state while the other thread is reduced, including in the cycle in which the other thread is released.
- R4: While `miss_limit` is nonzero, a thread whose miss count is greater than or equal to `miss_limit` has its `decode_inhibit` bit set from the next cycle.
- R5: A miss-inhibited thread is released when its miss count plus `miss_margin` is strictly less than `miss_limit`, or when its miss count is zero.
- R6: A zero `occ_limit` or `miss_limit` disables that check. No new throttle of that kind starts, and any active throttle of that kind is released at the next clock edge.
- R7: A thread's `sync_pend` bit going high while its sync controller is idle produces exactly one cycle of `flush_req` for that thread, in the next cycle. This holds even if the flag falls again at once.
- R8: `decode_inhibit` for a thread is high during its flush cycle and stays high while its `sync_pend` bit remains set. It falls one cycle after the flag clears, unless the miss throttle holds it.
- R9: Miss and sync throttles act per thread. Both threads may be throttled at once, and a thread with no cause of its own sees no throttle output.
- R10: After reset all of `prio_down`, `decode_inhibit` and `flush_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| occ_cnt | input | 2 x OCC_W | Completion-table entries held, per thread (index 0 = thread 0) |
| occ_limit | input | OCC_W | Occupancy threshold, 0 disables |
| occ_margin | input | OCC_W | Occupancy release margin |
| miss_cnt | input | 2 x MISS_W | Outstanding L2 load misses, per thread |
| miss_limit | input | MISS_W | Miss threshold, 0 disables |
| miss_margin | input | MISS_W | Miss release margin |
| sync_pend | input | 2 | Per-thread flag: long-running sync instruction pending |
| prio_down | output | 2 | Per-thread priority-reduction request |
| decode_inhibit | output | 2 | Per-thread decode inhibit (miss throttle or sync hold) |
| flush_req | output | 2 | Per-thread one-cycle flush request for undispatched instructions |

## Verification
The assertions check several properties on every cycle:
- at most one thread is reduced;
- a disabled check leaves no throttle active one edge later;
- a miss count at or above the limit always inhibits on the next cycle;
- a flush lasts a single cycle and follows a sampled pending flag;
- a flush always comes with decode inhibit, and the hold persists while the flag stays high.

Only the directed scenarios can show the behaviours that depend on counts, margins and history:
- the exact hysteresis release points;
- the higher-count and tie winner;
- the one-cycle blocking of a thread while the other is being released;
- release through a zero count when the margin exceeds the limit;
- the early-drop flush case.

// File: rtl/rbt_pkg.sv
package rbt_pkg;

    localparam int THREADS = 2;

    typedef enum logic {
        OC_NORMAL  = 1'b0,
        OC_REDUCED = 1'b1
    } occ_state_e;

    typedef enum logic {
        MS_CLEAR   = 1'b0,
        MS_INHIBIT = 1'b1
    } miss_state_e;

    typedef enum logic [1:0] {
        SY_IDLE  = 2'd0,
        SY_FLUSH = 2'd1,
        SY_HOLD  = 2'd2
    } sync_state_e;

endpackage

// File: rtl/rbt_occ_arb.sv
module rbt_occ_arb
    import rbt_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [THREADS-1:0][CNT_W-1:0]   cnt,
    input  logic [CNT_W-1:0]                limit,
    input  logic [CNT_W-1:0]                margin,
    output logic [THREADS-1:0]              reduce
);
    localparam int SUM_W = CNT_W + 1;

    logic [THREADS-1:0] over;
    logic [THREADS-1:0] calm;
    logic [THREADS-1:0] wins;
    logic [THREADS-1:0] is_normal;

    for (genvar i = 0; i < THREADS; i++) begin : g_thr
        localparam int  J       = THREADS - 1 - i;
        localparam bit  TIE_WIN = (i == 0);

        occ_state_e st_q;
        occ_state_e st_d;
        logic [SUM_W-1:0] relax_sum;

        assign relax_sum = {1'b0, cnt[i]} + {1'b0, margin};
        assign over[i]   = (limit != '0) && (cnt[i] > limit);
        assign calm[i]   = (limit == '0) || (cnt[i] == '0)
                         || (relax_sum < {1'b0, limit});
        assign wins[i]   = !over[J] || (cnt[i] > cnt[J])
                         || ((cnt[i] == cnt[J]) && TIE_WIN);

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= OC_NORMAL;
            else        st_q <= st_d;
        end

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                OC_NORMAL:  if (over[i] && is_normal[J] && wins[i]) st_d = OC_REDUCED;
                OC_REDUCED: if (calm[i])                            st_d = OC_NORMAL;
                default:    st_d = OC_NORMAL;
            endcase
        end

        always_comb begin
            is_normal[i] = (st_q == OC_NORMAL);
            reduce[i]    = (st_q == OC_REDUCED);
        end
    end

    a_r3_single_reduce: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reduce));

    a_r6_occ_off: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |=> (reduce == '0));

    a_r1_occ_enter: assert property (@(posedge clk) disable iff (!rst_n)
        ((limit != '0) && (cnt[0] > limit) && (cnt[1] <= limit) && !reduce[1])
        |=> reduce[0]);

endmodule

// File: rtl/rbt_miss_gate.sv
module rbt_miss_gate
    import rbt_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] margin,
    output logic             inhibit
);
    localparam int SUM_W = CNT_W + 1;

    miss_state_e      st_q;
    miss_state_e      st_d;
    logic             choke;
    logic             drain;
    logic [SUM_W-1:0] relax_sum;

    assign relax_sum = {1'b0, cnt} + {1'b0, margin};
    assign choke     = (limit != '0) && (cnt >= limit);
    assign drain     = (limit == '0) || (cnt == '0) || (relax_sum < {1'b0, limit});

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MS_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MS_CLEAR:   if (choke) st_d = MS_INHIBIT;
            MS_INHIBIT: if (drain) st_d = MS_CLEAR;
            default:    st_d = MS_CLEAR;
        endcase
    end

    always_comb inhibit = (st_q == MS_INHIBIT);

    a_r4_miss_enter: assert property (@(posedge clk) disable iff (!rst_n)
        ((limit != '0) && (cnt >= limit)) |=> inhibit);

    a_r6_miss_off: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |=> !inhibit);

endmodule

// File: rtl/rbt_sync_ctl.sv
module rbt_sync_ctl
    import rbt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    output logic flush,
    output logic hold
);
    sync_state_e st_q;
    sync_state_e st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SY_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SY_IDLE:  if (pend)  st_d = SY_FLUSH;
            SY_FLUSH: st_d = pend ? SY_HOLD : SY_IDLE;
            SY_HOLD:  if (!pend) st_d = SY_IDLE;
            default:  st_d = SY_IDLE;
        endcase
    end

    always_comb begin
        flush = (st_q == SY_FLUSH);
        hold  = (st_q == SY_FLUSH) || (st_q == SY_HOLD);
    end

    a_r7_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    a_r7_flush_after_pend: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(pend));

    a_r8_hold_while_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && pend) |=> hold);

endmodule

// File: rtl/rbt_throttle.sv
module rbt_throttle
    import rbt_pkg::*;
#(
    parameter int OCC_W  = 5,
    parameter int MISS_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [THREADS-1:0][OCC_W-1:0]  occ_cnt,
    input  logic [OCC_W-1:0]               occ_limit,
    input  logic [OCC_W-1:0]               occ_margin,
    input  logic [THREADS-1:0][MISS_W-1:0] miss_cnt,
    input  logic [MISS_W-1:0]              miss_limit,
    input  logic [MISS_W-1:0]              miss_margin,
    input  logic [THREADS-1:0]             sync_pend,
    output logic [THREADS-1:0]             prio_down,
    output logic [THREADS-1:0]             decode_inhibit,
    output logic [THREADS-1:0]             flush_req
);
    logic [THREADS-1:0] miss_inh;
    logic [THREADS-1:0] sync_hold;

    rbt_occ_arb #(.CNT_W(OCC_W)) u_occ (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (occ_cnt),
        .limit  (occ_limit),
        .margin (occ_margin),
        .reduce (prio_down)
    );

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        rbt_miss_gate #(.CNT_W(MISS_W)) u_miss (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (miss_cnt[t]),
            .limit   (miss_limit),
            .margin  (miss_margin),
            .inhibit (miss_inh[t])
        );

        rbt_sync_ctl u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pend  (sync_pend[t]),
            .flush (flush_req[t]),
            .hold  (sync_hold[t])
        );
    end

    assign decode_inhibit = miss_inh | sync_hold;

    a_r8_flush_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        ((flush_req & ~decode_inhibit) == '0));

    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (prio_down == '0) && (decode_inhibit == '0) && (flush_req == '0));

endmodule

// File: tb/rbt_throttle_test.sv
`timescale 1ns/1ps
module rbt_throttle_test;
    localparam int OW = 5;
    localparam int MW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0][OW-1:0] occ_cnt = '0;
    logic [OW-1:0] occ_limit = '0, occ_margin = '0;
    logic [1:0][MW-1:0] miss_cnt = '0;
    logic [MW-1:0] miss_limit = '0, miss_margin = '0;
    logic [1:0] sync_pend = '0;
    logic [1:0] prio_down, decode_inhibit, flush_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rbt_throttle #(.OCC_W(OW), .MISS_W(MW)) uut (
        .clk(clk), .rst_n(rst_n),
        .occ_cnt(occ_cnt), .occ_limit(occ_limit), .occ_margin(occ_margin),
        .miss_cnt(miss_cnt), .miss_limit(miss_limit), .miss_margin(miss_margin),
        .sync_pend(sync_pend),
        .prio_down(prio_down), .decode_inhibit(decode_inhibit), .flush_req(flush_req)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string req, string what, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic quiesce();
        occ_cnt = '0; miss_cnt = '0; sync_pend = '0;
        occ_limit = 5'd10; occ_margin = 5'd2;
        miss_limit = 4'd4; miss_margin = 4'd1;
        step(); step();
    endtask

    task automatic t_reset();
        check("R10", "prio_down", prio_down, 2'b00);
        check("R10", "decode_inhibit", decode_inhibit, 2'b00);
        check("R10", "flush_req", flush_req, 2'b00);
    endtask

    task automatic t_occ_hyst();
        quiesce();
        occ_cnt[0] = 5'd10; step();
        check("R1", "equal to limit", prio_down, 2'b00);
        occ_cnt[0] = 5'd11; step();
        check("R1", "above limit", prio_down, 2'b01);
        occ_cnt[0] = 5'd8; step();
        check("R2", "inside margin", prio_down, 2'b01);
        occ_cnt[0] = 5'd7; step();
        check("R2", "below margin", prio_down, 2'b00);
    endtask

    task automatic t_occ_arb();
        quiesce();
        occ_cnt[0] = 5'd12; occ_cnt[1] = 5'd15; step();
        check("R3", "higher count wins", prio_down, 2'b10);
        occ_cnt[1] = 5'd5; step();
        check("R3", "blocked during release", prio_down, 2'b00);
        step();
        check("R3", "enters after release", prio_down, 2'b01);
        quiesce();
        occ_cnt[0] = 5'd12; occ_cnt[1] = 5'd12; step();
        check("R3", "tie to thread 0", prio_down, 2'b01);
    endtask

    task automatic t_occ_off();
        quiesce();
        occ_cnt[1] = 5'd20; step();
        check("R6", "occ before disable", prio_down, 2'b10);
        occ_limit = '0; step();
        check("R6", "occ disabled", prio_down, 2'b00);
        step();
        check("R6", "occ stays off", prio_down, 2'b00);
    endtask

    task automatic t_miss();
        quiesce();
        miss_cnt[0] = 4'd3; step();
        check("R4", "below miss limit", decode_inhibit, 2'b00);
        miss_cnt[0] = 4'd4; step();
        check("R4", "at miss limit", decode_inhibit, 2'b01);
        miss_cnt[0] = 4'd3; step();
        check("R5", "inside miss margin", decode_inhibit, 2'b01);
        miss_cnt[0] = 4'd2; step();
        check("R5", "below miss margin", decode_inhibit, 2'b00);
        miss_margin = 4'd9; miss_cnt[1] = 4'd6; step();
        check("R5", "wide margin enter", decode_inhibit, 2'b10);
        miss_cnt[1] = 4'd1; step();
        check("R5", "wide margin holds", decode_inhibit, 2'b10);
        miss_cnt[1] = 4'd0; step();
        check("R5", "zero count release", decode_inhibit, 2'b00);
    endtask

    task automatic t_miss_off();
        quiesce();
        miss_cnt[0] = 4'd9; step();
        check("R6", "miss before disable", decode_inhibit, 2'b01);
        miss_limit = '0; step();
        check("R6", "miss disabled", decode_inhibit, 2'b00);
    endtask

    task automatic t_sync();
        quiesce();
        sync_pend[0] = 1'b1; step();
        check("R7", "flush pulse", flush_req, 2'b01);
        check("R8", "hold in flush", decode_inhibit, 2'b01);
        step();
        check("R7", "pulse ends", flush_req, 2'b00);
        check("R8", "hold persists", decode_inhibit, 2'b01);
        step();
        check("R8", "hold persists 2", decode_inhibit, 2'b01);
        sync_pend[0] = 1'b0; step();
        check("R8", "hold released", decode_inhibit, 2'b00);
        sync_pend[1] = 1'b1; step();
        sync_pend[1] = 1'b0;
        check("R7", "short flag flush", flush_req, 2'b10);
        step();
        check("R7", "short flag done", flush_req, 2'b00);
        check("R8", "short flag no hold", decode_inhibit, 2'b00);
    endtask

    task automatic t_indep();
        quiesce();
        miss_cnt[0] = 4'd5; miss_cnt[1] = 4'd7; step();
        check("R9", "both miss throttled", decode_inhibit, 2'b11);
        miss_cnt = '0; step();
        check("R9", "both released", decode_inhibit, 2'b00);
        sync_pend[1] = 1'b1; step();
        check("R9", "only thread 1 flushed", flush_req, 2'b10);
        check("R9", "only thread 1 held", decode_inhibit, 2'b10);
        check("R9", "no priority effect", prio_down, 2'b00);
        sync_pend[1] = 1'b0; step();
    endtask

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_occ_hyst();
        t_occ_arb();
        t_occ_off();
        t_miss();
        t_miss_off();
        t_sync();
        t_indep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule